// File: doc/BRIEF.md
# Pseudo-SRAM Synchronous Burst Controller

This block is the synchronous access engine of a pseudo-static RAM. A host issues a burst by pulling the address-advance strobe low and releasing it while the first chip enable is low. On the clock edge that sees the strobe rise, the start address is captured. That latch starts a latency count. Once the count is complete, one 16-bit word moves per clock through an internal address counter. The counter either wraps inside an aligned block of the burst length or keeps stepping upward. The word storage is a small array inside the block.

How a burst behaves is set by a configuration register. The register loads from the address bus itself: the host performs a latch with the write enable low and the top address bit set, and the field values are taken from fixed address bit positions. Until such a key has selected synchronous operation, burst requests are dropped. During a read, raising output enable pauses the burst. Raising the first chip enable ends it. Pulling the second chip enable low puts the whole block into a sleep state. A wait output marks the latency window, and it is released from driving whenever the first chip enable is high.

Top module: `psram_burst_ctrl`

## Requirements
- R1: A latch with `weN` low and `addr[22]` high loads the configuration register instead of starting a burst. The fields are: `addr[20:19]` sleep-retention select, `addr[18:16]` burst length, `addr[15]` access mode (0 = synchronous bursts allowed), `addr[14:12]` latency, `addr[11]` wrap select and `addr[9]` write-control select.
- R2: After reset, and whenever the last key loaded set `addr[15]` to 1, a latch starts no burst: `rdValid` stays 0 and `waitN` stays 1.
- R3: A burst latches its start address (low address bits) on the clock edge where `advN` is sampled high after being sampled low in the previous cycle, with `ce1N` low. Its write-or-read direction is `weN` at that edge.
- R4: For a read, the first word is presented with `rdValid` high after the edge that lies RL edges past the latch edge. Latency code 3'b011 gives RL=3, 3'b100 gives RL=4, and any other code gives RL=5. Write data is sampled on that same edge.
- R5: `waitN` is 0 from the latch edge until the edge of the first data beat. `waitOe` is 0 whenever `ce1N` is high.
- R6: Length code 3'b010 gives 8 beats, 3'b011 gives 16 and 3'b100 gives 32; any other code gives a continuous burst. With `addr[11]`=0 the address wraps inside the aligned block of the burst length. With `addr[11]`=1 it increments linearly. A fixed-length burst stops after its last beat.
- R7: During a read, a clock edge with `oeN` high produces no beat and does not advance the address. The next edge with `oeN` low delivers the next address.
- R8: `ce1N` high at a clock edge ends any burst. Lowering `ce1N` again without a new latch produces no data.
- R9: `ce2` low enters a sleep state in which all inputs are ignored and no data moves. The state is left on the first edge with `ce2` high. If the sleep-retention field is 2'b00 when sleep is entered, the configuration is cleared; any other value keeps it.
- R10: With `addr[9]`=0, a write beat happens only on edges where `weN` is low, and a high `weN` pauses the burst. With `addr[9]`=1, `weN` is a single low pulse at the latch, and every edge after the latency is a beat.
- R11: On a write beat, `lbN` low writes bits 7:0 and `ubN` low writes bits 15:8. A lane whose enable is high keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rstN | input | 1 | Active-low reset |
| ce1N | input | 1 | Active-low chip enable; high ends a burst |
| ce2 | input | 1 | Active-high enable; low selects sleep |
| oeN | input | 1 | Active-low output enable; high pauses reads |
| weN | input | 1 | Active-low write enable |
| lbN | input | 1 | Active-low lower byte lane enable |
| ubN | input | 1 | Active-low upper byte lane enable |
| advN | input | 1 | Address-advance strobe; address latched on its rise |
| addr | input | 23 | Start address or configuration key |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data |
| rdValid | output | 1 | High when rdData holds a new beat |
| waitN | output | 1 | Low during the latency window |
| waitOe | output | 1 | Drive enable for waitN; low means high-impedance |

## Verification
The properties assume that `ce1N`, `ce2`, `oeN`, `weN` and `advN` change only away from the rising clock edge. They also assume the configured latency is at least three cycles, which every defined latency code guarantees. The directed stimulus changes all inputs on the falling edge only. It always holds `advN` low for one full cycle before releasing it, and it loads a configuration key before each scenario that depends on one.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

  // Configuration key bit positions; the decode depends on them.
  localparam int KEY_PD_LSB   = 19;
  localparam int KEY_LEN_LSB  = 16;
  localparam int KEY_MODE_BIT = 15;
  localparam int KEY_LAT_LSB  = 12;
  localparam int KEY_WRAP_BIT = 11;
  localparam int KEY_WEP_BIT  = 9;
  localparam int LAT_W        = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_XFER,
    ST_SLEEP
  } seqState_t;

  typedef struct packed {
    logic             valid;
    logic [1:0]       pdSel;
    logic [2:0]       lenCode;
    logic             asyncSel;
    logic [LAT_W-1:0] latCode;
    logic             noWrap;
    logic             wePulse;
  } cfg_t;

  typedef struct packed {
    logic loadAddr;
    logic rdBeat;
    logic wrBeat;
    logic noWrap;
  } dpCtl_t;

endpackage

// File: rtl/psram_burst_ctl.sv
module psram_burst_ctl
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int MEM_AW    = 6,
  parameter int MAX_BURST = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  output dpCtl_t            dpCtl,
  output logic [MEM_AW-1:0] wrapMask,
  output logic              waitN,
  output logic              waitOe
);

  localparam int BEAT_W = $clog2(MAX_BURST) + 1;
  localparam logic [LAT_W-1:0] LAT_SAT = '1;
  localparam cfg_t CFG_RESET = '{valid: 1'b0, pdSel: 2'b01, lenCode: 3'b111,
                                 asyncSel: 1'b0, latCode: 3'b101,
                                 noWrap: 1'b0, wePulse: 1'b0};

  seqState_t         state;
  cfg_t              cfg;
  cfg_t              keyCfg;
  logic              advQ;
  logic              isWr;
  logic [LAT_W-1:0]  latCnt;
  logic [LAT_W-1:0]  latVal;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lenVal;
  logic [BEAT_W-1:0] beatNext;
  logic [2:0]        lenLog;
  logic              contBurst;
  logic [31:0]       maskFull;
  logic              active;
  logic              addrLatch;
  logic              keyWrite;
  logic              burstOk;
  logic              goNow;
  logic              beatNow;

  // Decode of the stored configuration
  always_comb begin
    contBurst = 1'b0;
    lenLog    = 3'd3;
    unique case (cfg.lenCode)
      3'b010:  lenLog = 3'd3;
      3'b011:  lenLog = 3'd4;
      3'b100:  lenLog = 3'd5;
      default: contBurst = 1'b1;
    endcase
    unique case (cfg.latCode)
      3'b011:  latVal = LAT_W'(3);
      3'b100:  latVal = LAT_W'(4);
      default: latVal = LAT_W'(5);
    endcase
  end

  assign lenVal   = BEAT_W'(1) << lenLog;
  assign maskFull = (32'd1 << lenLog) - 32'd1;
  assign wrapMask = contBurst ? '1 : maskFull[MEM_AW-1:0];
  assign beatNext = beatCnt + BEAT_W'(1);

  // Key fields taken straight from the address bus
  always_comb begin
    keyCfg          = CFG_RESET;
    keyCfg.valid    = 1'b1;
    keyCfg.pdSel    = addr[KEY_PD_LSB +: 2];
    keyCfg.lenCode  = addr[KEY_LEN_LSB +: 3];
    keyCfg.asyncSel = addr[KEY_MODE_BIT];
    keyCfg.latCode  = addr[KEY_LAT_LSB +: LAT_W];
    keyCfg.noWrap   = addr[KEY_WRAP_BIT];
    keyCfg.wePulse  = addr[KEY_WEP_BIT];
  end

  assign active    = ce2 && (state != ST_SLEEP) && !ce1N;
  assign addrLatch = !advQ && advN;
  assign keyWrite  = !weN && addr[ADDR_W-1];
  assign burstOk   = cfg.valid && !cfg.asyncSel;
  assign goNow     = isWr ? (cfg.wePulse || !weN) : !oeN;
  assign beatNow   = active && !addrLatch && goNow &&
                     (((state == ST_LAT) && (latCnt >= latVal)) || (state == ST_XFER));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfg     <= CFG_RESET;
      advQ    <= 1'b1;
      isWr    <= 1'b0;
      latCnt  <= '0;
      beatCnt <= '0;
    end else begin
      advQ <= advN;
      if (!ce2) begin
        if ((state != ST_SLEEP) && (cfg.pdSel == 2'b00)) cfg.valid <= 1'b0;
        state <= ST_SLEEP;
      end else if (state == ST_SLEEP) begin
        state <= ST_IDLE;
      end else if (ce1N) begin
        state <= ST_IDLE;
      end else if (addrLatch) begin
        if (keyWrite) begin
          cfg   <= keyCfg;
          state <= ST_IDLE;
        end else if (burstOk) begin
          state   <= ST_LAT;
          latCnt  <= LAT_W'(1);
          beatCnt <= '0;
          isWr    <= !weN;
        end else begin
          state <= ST_IDLE;
        end
      end else if (beatNow) begin
        beatCnt <= beatNext;
        state   <= (!contBurst && (beatNext == lenVal)) ? ST_IDLE : ST_XFER;
      end else if ((state == ST_LAT) && (latCnt != LAT_SAT)) begin
        latCnt <= latCnt + LAT_W'(1);
      end
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.loadAddr = active && addrLatch && !keyWrite && burstOk;
    dpCtl.rdBeat   = beatNow && !isWr;
    dpCtl.wrBeat   = beatNow && isWr;
    dpCtl.noWrap   = cfg.noWrap;
  end

  assign waitN  = (state != ST_LAT);
  assign waitOe = !ce1N && ce2;

endmodule

// File: rtl/psram_burst_dp.sv
module psram_burst_dp
  import psram_burst_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [MEM_AW-1:0] startAddr,
  input  logic [MEM_AW-1:0] wrapMask,
  input  logic [LANES-1:0]  laneN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int DEPTH  = 1 << MEM_AW;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] ptr;
  logic [MEM_AW-1:0] ptrInc;
  logic [MEM_AW-1:0] nextPtr;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] mergedWord;

  assign ptrInc  = ptr + MEM_AW'(1);
  assign nextPtr = dpCtl.noWrap ? ptrInc : ((ptr & ~wrapMask) | (ptrInc & wrapMask));
  assign curWord = mem[ptr];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign mergedWord[ln*LANE_W +: LANE_W] =
      laneN[ln] ? curWord[ln*LANE_W +: LANE_W] : wrData[ln*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (dpCtl.wrBeat) mem[ptr] <= mergedWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtl.rdBeat;
      if (dpCtl.loadAddr) begin
        ptr <= startAddr;
      end else if (dpCtl.rdBeat || dpCtl.wrBeat) begin
        ptr <= nextPtr;
      end
      if (dpCtl.rdBeat) rdData <= curWord;
    end
  end

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int MEM_AW = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              waitN,
  output logic              waitOe
);

  dpCtl_t            dpCtl;
  logic [MEM_AW-1:0] wrapMask;

  psram_burst_ctl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) ctl_i (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN),
    .advN(advN), .addr(addr), .dpCtl(dpCtl), .wrapMask(wrapMask),
    .waitN(waitN), .waitOe(waitOe)
  );

  psram_burst_dp #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .startAddr(addr[MEM_AW-1:0]),
    .wrapMask(wrapMask), .laneN({ubN, lbN}), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk
  import psram_burst_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   ce1N,
  input logic   ce2,
  input logic   oeN,
  input logic   rdValid,
  input logic   waitN,
  input dpCtl_t dpCtl
);

  logic [2:0] sinceLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLoad <= '0;
    else if (dpCtl.loadAddr) sinceLoad <= 3'd1;
    else if (sinceLoad != 3'd7) sinceLoad <= sinceLoad + 3'd1;
  end

  AST_LATENCY_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.rdBeat |-> (sinceLoad >= 3'd3)); // R4

  AST_WAIT_CLEARS_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> waitN); // R5

  AST_WAIT_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> !rdValid); // R5

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !$past(oeN)); // R7

  AST_END_ON_CE1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ce1N) |-> !rdValid); // R8

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ce2) |-> !rdValid); // R9

endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk chk_i (.*);

// File: tb/psram_burst_ctrl_tb_top.sv
module psram_burst_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ce1N, ce2, oeN, weN, lbN, ubN, advN;
  logic [22:0] addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        rdValid, waitN, waitOe;

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 0;
  logic [15:0] refMem [64];

  always #4 clk = ~clk;

  psram_burst_ctrl dut_i (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN),
    .lbN(lbN), .ubN(ubN), .advN(advN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .waitN(waitN), .waitOe(waitOe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] key(input logic [1:0] pd, input logic [2:0] len, input logic md,
                                      input logic [2:0] rl, input logic nw, input logic wp);
    logic [22:0] k;
    k = '0;
    k[22] = 1'b1; k[20:19] = pd; k[18:16] = len; k[15] = md;
    k[14:12] = rl; k[11] = nw; k[9] = wp;
    return k;
  endfunction

  function automatic int nxt(input int a, input int lenLog, input bit nw, input bit cont);
    int m;
    if (nw || cont) return (a + 1) % 64;
    m = (1 << lenLog) - 1;
    return (a & ~m) | ((a + 1) & m);
  endfunction

  function automatic logic [15:0] pat(input int a, input int seed);
    return 16'((a * 2323) ^ (seed * 23100) ^ 16'h5a0f);
  endfunction

  task automatic latchAt(input logic [22:0] a, input bit wr, input bit rd);
    @(negedge clk);
    ce1N = 1'b0; advN = 1'b0; addr = a; weN = !wr; oeN = !rd;
    @(negedge clk);
    advN = 1'b1;
  endtask

  task automatic endAccess();
    ce1N = 1'b1; oeN = 1'b1; weN = 1'b1; lbN = 1'b0; ubN = 1'b0;
    @(negedge clk);
  endtask

  // R1: load a configuration key through a latch with weN low and addr[22] high
  task automatic keyLoad(input logic [22:0] k);
    latchAt(k, 1'b1, 1'b0);
    @(negedge clk);
    endAccess();
  endtask

  // R3 R4 R5: latency window checks
  task automatic latency(input int rl, input bit pulse);
    for (int i = 1; i <= rl; i++) begin
      @(negedge clk);
      if (pulse && i == 1) weN = 1'b1;
      chk(waitN == 1'b0 && waitOe == 1'b1, "R5 wait low in latency", {waitOe, waitN}, 2'b10);
      chk(rdValid == 1'b0, "R4 no data before latency", rdValid, 0);
    end
  endtask

  task automatic readBurst(input int start, input int rl, input int n, input int lenLog,
                           input bit nw, input bit cont, input int susp, input string tag);
    int  a = start;
    int  i = 0;
    bit  did = 0;
    latchAt(23'(start), 1'b0, 1'b1);
    latency(rl, 1'b0);
    while (i < n) begin
      if (i == susp && !did) begin
        oeN = 1'b1;
        @(negedge clk);
        chk(rdValid == 1'b0, "R7 no beat while oeN high", rdValid, 0);
        oeN = 1'b0;
        did = 1;
      end else begin
        @(negedge clk);
        chk(rdValid == 1'b1 && rdData == refMem[a], tag, {rdValid, rdData}, {1'b1, refMem[a]});
        if (i == 0) chk(waitN == 1'b1, "R5 wait released at first beat", waitN, 1);
        a = nxt(a, lenLog, nw, cont);
        i++;
      end
    end
    if (!cont) begin
      @(negedge clk);
      chk(rdValid == 1'b0, "R6 burst stops after length", rdValid, 0);
    end
  endtask

  task automatic writeBurst(input int start, input int rl, input int n, input int lenLog,
                            input bit nw, input bit cont, input bit pulse, input int pauseAt,
                            input int lbSkip, input int ubSkip, input int seed);
    int  a = start;
    int  i = 0;
    bit  did = 0;
    logic [15:0] d;
    latchAt(23'(start), 1'b1, 1'b0);
    latency(rl, pulse);
    while (i < n) begin
      if (i == pauseAt && !did) begin
        weN = 1'b1;
        @(negedge clk);
        weN = 1'b0;
        did = 1;
      end else begin
        d = pat(a, seed);
        wrData = d;
        lbN = (i == lbSkip);
        ubN = (i == ubSkip);
        @(negedge clk);
        if (!lbN) refMem[a][7:0]  = d[7:0];
        if (!ubN) refMem[a][15:8] = d[15:8];
        a = nxt(a, lenLog, nw, cont);
        i++;
      end
    end
  endtask

  task automatic noDataFor(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(rdValid == 1'b0 && waitN == 1'b1, tag, {rdValid, waitN}, 2'b01);
    end
  endtask

  task automatic tReset();
    chk(rdValid == 1'b0, "R5 reset rdValid", rdValid, 0);
    chk(waitOe == 1'b0 && waitN == 1'b1, "R5 reset wait released", {waitOe, waitN}, 2'b01);
  endtask

  task automatic tNoConfig();
    latchAt(23'd3, 1'b0, 1'b1);
    noDataFor(8, "R2 burst before configuration");
    endAccess();
  endtask

  task automatic tFillLevel();
    keyLoad(key(2'b01, 3'b111, 1'b0, 3'b011, 1'b0, 1'b0));
    writeBurst(0, 3, 32, 0, 1'b0, 1'b1, 1'b0, 5, -1, -1, 1); // R10 level pause, R3
    endAccess();
    readBurst(0, 3, 32, 0, 1'b0, 1'b1, -1, "R10 level write readback");
    endAccess();
  endtask

  task automatic tWrapRead();
    keyLoad(key(2'b01, 3'b010, 1'b0, 3'b100, 1'b0, 1'b0)); // R1 R4 R6
    readBurst(5, 4, 8, 3, 1'b0, 1'b0, 3, "R6 R7 wrap of 8 with suspend");
    endAccess();
  endtask

  task automatic tLinearRead();
    keyLoad(key(2'b01, 3'b010, 1'b0, 3'b101, 1'b1, 1'b0)); // R1 R4 R6
    readBurst(5, 5, 8, 3, 1'b1, 1'b0, -1, "R6 linear 8 beats latency 5");
    endAccess();
  endtask

  task automatic tPulseLanes();
    keyLoad(key(2'b01, 3'b011, 1'b0, 3'b011, 1'b0, 1'b1));
    writeBurst(20, 3, 16, 4, 1'b0, 1'b0, 1'b1, -1, 2, 4, 7); // R10 pulse, R11 lanes
    endAccess();
    readBurst(16, 3, 16, 4, 1'b0, 1'b0, -1, "R11 R10 pulse write with lanes");
    endAccess();
  endtask

  task automatic tTerminate();
    keyLoad(key(2'b01, 3'b111, 1'b0, 3'b011, 1'b0, 1'b0));
    readBurst(2, 3, 4, 0, 1'b0, 1'b1, -1, "R8 continuous read");
    ce1N = 1'b1;
    @(negedge clk);
    chk(rdValid == 1'b0 && waitOe == 1'b0, "R8 ce1N high ends burst", {rdValid, waitOe}, 0);
    ce1N = 1'b0;
    noDataFor(4, "R8 no data after end");
    endAccess();
  endtask

  task automatic tSleep();
    keyLoad(key(2'b01, 3'b111, 1'b0, 3'b011, 1'b0, 1'b0));
    ce2 = 1'b0;
    latchAt(23'd0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rdValid == 1'b0 && waitOe == 1'b0, "R9 sleep ignores latch", {rdValid, waitOe}, 0);
    end
    endAccess();
    ce2 = 1'b1;
    @(negedge clk);
    readBurst(0, 3, 3, 0, 1'b0, 1'b1, -1, "R9 config kept across sleep");
    endAccess();
    keyLoad(key(2'b00, 3'b111, 1'b0, 3'b011, 1'b0, 1'b0));
    ce2 = 1'b0;
    repeat (2) @(negedge clk);
    ce2 = 1'b1;
    @(negedge clk);
    latchAt(23'd0, 1'b0, 1'b1);
    noDataFor(8, "R9 config cleared by sleep select 00");
    endAccess();
  endtask

  task automatic tAsyncMode();
    keyLoad(key(2'b01, 3'b111, 1'b1, 3'b011, 1'b0, 1'b0));
    latchAt(23'd1, 1'b0, 1'b1);
    noDataFor(8, "R2 async mode blocks bursts");
    endAccess();
  endtask

  initial begin
    rstN = 1'b0; ce1N = 1'b1; ce2 = 1'b1; oeN = 1'b1; weN = 1'b1;
    lbN = 1'b0; ubN = 1'b0; advN = 1'b1; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNoConfig();
    tFillLevel();
    tWrapRead();
    tLinearRead();
    tPulseLanes();
    tTerminate();
    tSleep();
    tAsyncMode();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule